// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. It holds up to five register groups of 32 pins each. Software sets the direction of each pin and changes output levels through write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. It can read back the level of every pin and can enable rising-edge detection, falling-edge detection or both on each pin.

Every pin level passes through a clock synchronizer. A detected edge on an enabled pin latches a sticky status bit, which software clears by writing ones to it. Status bits are grouped into banks of 16 pins, two banks per register group. Each bank drives one level interrupt line, gated by a bank enable word.

The register port is a plain single-cycle interface. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every direction bit reads 1 (all pins inputs, `pin_oe` all low). Output data, edge enables, status bits and bank enables all read 0, and `bank_irq` is low.
- R2: The direction word sits at group offset 0x00 and can be read and written. A 0 bit makes the pin an output: its `pin_oe` bit goes high and `pin_out` carries its output data bit.
- R3: Writing ones to the set-data word (group offset 0x08) sets those output bits, and writing ones to the clear-data word (offset 0x0C) clears them. Zero bits leave outputs unchanged. Both words read back the output data, and `pin_out` changes only after a register write.
- R4: The output data word at group offset 0x04 can also be written directly and reads back the stored value.
- R5: The input word at group offset 0x10 returns the pin level after a two-flop synchronizer. A read taken one clock after a pin change still returns the old level, and a read taken two clocks after returns the new level.
- R6: Register group k starts at byte 0x10 + 0x28*k (0x10, 0x38, 0x60, 0x88, 0xB0). Its words are, in order: direction, output, set, clear, input, rise-set, rise-clear, fall-set, fall-clear, status. Groups do not affect one another.
- R7: The rising-edge enables change only through the rise-set word (0x14) and the rise-clear word (0x18), using write-one semantics. The falling-edge enables behave the same way through 0x1C and 0x20. Both words of a pair read back the current enables.
- R8: A rising or falling pin change on a pin with that edge enabled sets its status bit (group offset 0x24) on the third clock edge after the change. Edges that are not enabled never set status. A pin with both edges enabled reports both.
- R9: Writing ones to the status word clears those bits, and zero bits have no effect. If an edge arrives in the same cycle as the clear of its bit, the bit stays set.
- R10: The bank enable word at byte 0x08 has one bit per bank. Bank 2k covers status bits 15:0 of group k, and bank 2k+1 covers bits 31:16. `bank_irq[b]` is high exactly while enable bit b is set and any status bit of bank b is set.
- R11: Reads of unmapped or unaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, applied at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32*NUM_SETS (160) | Pad input levels, asynchronous |
| pin_out | output | 32*NUM_SETS (160) | Output data driven to the pads |
| pin_oe | output | 32*NUM_SETS (160) | Pad output enable, high for output pins |
| bank_irq | output | 2*NUM_SETS (10) | Level interrupt per 16-pin bank |

## Verification
The properties assume that `bus_we` is the only source of change for software-held state, and that pin levels are sampled only through the synchronizer. The bench therefore changes `pin_in` and the bus signals only at falling clock edges, and it holds each pin level for at least three clock edges before it samples status. A pin change and a status clear are placed on the same edge only in the deliberate collision case. Addresses are word-aligned except in the one probe that checks unaligned decoding.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS_PER_SET  = 32;
    localparam int PINS_PER_BANK = 16;
    localparam int SET_WORDS     = 10;
    localparam int SET_SPAN      = SET_WORDS * 4;   // bytes per group
    localparam int FIRST_SET     = 'h10;
    localparam int BANK_EN_ADDR  = 'h08;

    // Word index inside one register group; the order sets the address map.
    typedef enum logic [3:0] {
        W_DIR  = 4'd0,
        W_OUT  = 4'd1,
        W_SET  = 4'd2,
        W_CLR  = 4'd3,
        W_IN   = 4'd4,
        W_RSET = 4'd5,
        W_RCLR = 4'd6,
        W_FSET = 4'd7,
        W_FCLR = 4'd8,
        W_STAT = 4'd9
    } word_e;

    // State held for one group of 32 pins.
    typedef struct packed {
        logic [PINS_PER_SET-1:0] dir;
        logic [PINS_PER_SET-1:0] dout;
        logic [PINS_PER_SET-1:0] rise_en;
        logic [PINS_PER_SET-1:0] fall_en;
        logic [PINS_PER_SET-1:0] stat;
    } grp_state_t;

    function automatic int grp_base(input int k);
        return FIRST_SET + k * SET_SPAN;
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
    import gpio_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  word_e                   word,
    input  logic                    we,
    input  logic [PINS_PER_SET-1:0] wdata,
    input  logic [PINS_PER_SET-1:0] lvl,
    input  logic [PINS_PER_SET-1:0] rise_evt,
    input  logic [PINS_PER_SET-1:0] fall_evt,
    output logic [PINS_PER_SET-1:0] rdata,
    output grp_state_t              st
);
    grp_state_t st_q;
    logic       wr_hit;
    logic [PINS_PER_SET-1:0] ack_mask, evt;

    assign wr_hit   = we && sel;
    assign ack_mask = (wr_hit && word == W_STAT) ? wdata : '0;
    assign evt      = (rise_evt & st_q.rise_en) | (fall_evt & st_q.fall_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dir     <= '1;
            st_q.dout    <= '0;
            st_q.rise_en <= '0;
            st_q.fall_en <= '0;
            st_q.stat    <= '0;
        end else begin
            if (wr_hit) begin
                case (word)
                    W_DIR:   st_q.dir     <= wdata;
                    W_OUT:   st_q.dout    <= wdata;
                    W_SET:   st_q.dout    <= st_q.dout | wdata;
                    W_CLR:   st_q.dout    <= st_q.dout & ~wdata;
                    W_RSET:  st_q.rise_en <= st_q.rise_en | wdata;
                    W_RCLR:  st_q.rise_en <= st_q.rise_en & ~wdata;
                    W_FSET:  st_q.fall_en <= st_q.fall_en | wdata;
                    W_FCLR:  st_q.fall_en <= st_q.fall_en & ~wdata;
                    default: ;
                endcase
            end
            // new events win over a simultaneous acknowledge
            st_q.stat <= (st_q.stat & ~ack_mask) | evt;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (word)
                W_DIR:                rdata = st_q.dir;
                W_OUT, W_SET, W_CLR:  rdata = st_q.dout;
                W_IN:                 rdata = lvl;
                W_RSET, W_RCLR:       rdata = st_q.rise_en;
                W_FSET, W_FCLR:       rdata = st_q.fall_en;
                W_STAT:               rdata = st_q.stat;
                default:              rdata = '0;
            endcase
        end
    end

    assign st = st_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_SETS = 5,
    parameter int ADDR_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic                             bus_we,
    input  logic [31:0]                      bus_wdata,
    output logic [31:0]                      bus_rdata,
    input  logic [PINS_PER_SET*NUM_SETS-1:0] pin_in,
    output logic [PINS_PER_SET*NUM_SETS-1:0] pin_out,
    output logic [PINS_PER_SET*NUM_SETS-1:0] pin_oe,
    output logic [2*NUM_SETS-1:0]            bank_irq
);
    localparam int NPINS  = PINS_PER_SET * NUM_SETS;
    localparam int NBANKS = 2 * NUM_SETS;

    logic [NBANKS-1:0] bank_en;
    logic [NPINS-1:0]  pin_lvl, pin_rise, pin_fall;
    logic [NPINS-1:0]  stat_all, edge_en_all;
    logic [31:0]       grp_rd [NUM_SETS];
    logic              en_hit;

    gpio_sync_edge #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pad  (pin_in),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_grp
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(grp_base(k));
        logic [ADDR_W-1:0] rel;
        logic              hit;
        grp_state_t        st;

        assign rel = bus_addr - BASE;
        assign hit = (bus_addr >= BASE) && (rel < ADDR_W'(SET_SPAN)) && (rel[1:0] == 2'b00);

        gpio_regset u_set (
            .clk      (clk),
            .rst      (rst),
            .sel      (hit),
            .word     (word_e'(rel[5:2])),
            .we       (bus_we),
            .wdata    (bus_wdata),
            .lvl      (pin_lvl [k*PINS_PER_SET +: PINS_PER_SET]),
            .rise_evt (pin_rise[k*PINS_PER_SET +: PINS_PER_SET]),
            .fall_evt (pin_fall[k*PINS_PER_SET +: PINS_PER_SET]),
            .rdata    (grp_rd[k]),
            .st       (st)
        );

        assign pin_out    [k*PINS_PER_SET +: PINS_PER_SET] = st.dout;
        assign pin_oe     [k*PINS_PER_SET +: PINS_PER_SET] = ~st.dir;
        assign stat_all   [k*PINS_PER_SET +: PINS_PER_SET] = st.stat;
        assign edge_en_all[k*PINS_PER_SET +: PINS_PER_SET] = st.rise_en | st.fall_en;

        for (genvar h = 0; h < 2; h++) begin : g_half
            assign bank_irq[2*k+h] = bank_en[2*k+h] &
                                     (|st.stat[h*PINS_PER_BANK +: PINS_PER_BANK]);
        end
    end

    assign en_hit = (bus_addr == ADDR_W'(BANK_EN_ADDR));

    always_ff @(posedge clk) begin
        if (rst)
            bank_en <= '0;
        else if (bus_we && en_hit)
            bank_en <= bus_wdata[NBANKS-1:0];
    end

    always_comb begin
        bus_rdata = en_hit ? 32'(bank_en) : 32'd0;
        for (int k = 0; k < NUM_SETS; k++)
            bus_rdata = bus_rdata | grp_rd[k];
    end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int NUM_SETS = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_we,
    input logic [32*NUM_SETS-1:0]   pin_out,
    input logic [32*NUM_SETS-1:0]   pin_oe,
    input logic [2*NUM_SETS-1:0]    bank_irq,
    input logic [2*NUM_SETS-1:0]    bank_en,
    input logic [32*NUM_SETS-1:0]   stat_all,
    input logic [32*NUM_SETS-1:0]   edge_en_all
);
    // R1
    reset_inputs_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && bank_irq == '0));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> $stable(pin_out));

    // R8
    status_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_all & ~$past(stat_all)) & ~$past(edge_en_all)) == '0);

    // R9
    status_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat_all) & ~stat_all)) |-> $past(bus_we));

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_irq & ~bank_en) == '0);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_SETS(NUM_SETS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .bank_irq    (bank_irq),
    .bank_en     (bank_en),
    .stat_all    (stat_all),
    .edge_en_all (edge_en_all)
);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
    localparam int NS = 5;
    localparam int NP = 32 * NS;
    localparam int NB = 2 * NS;
    localparam int NV = 35;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [NB-1:0] bank_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_ctrl #(.NUM_SETS(NS), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    // {write, addr, data, expected read}
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h10, 32'h0, 32'hFFFF_FFFF},        // 0  R1 dir reset
        {1'b0, 8'h14, 32'h0, 32'h0},                // 1  R1 out reset
        {1'b0, 8'h34, 32'h0, 32'h0},                // 2  R1 status reset
        {1'b0, 8'h08, 32'h0, 32'h0},                // 3  R1 bank enable reset
        {1'b1, 8'h18, 32'hA5A5_0003, 32'h0},        // 4  set word
        {1'b0, 8'h14, 32'h0, 32'hA5A5_0003},        // 5  R3
        {1'b0, 8'h1C, 32'h0, 32'hA5A5_0003},        // 6  R3 clear word reads out
        {1'b1, 8'h1C, 32'h0000_0001, 32'h0},        // 7
        {1'b0, 8'h14, 32'h0, 32'hA5A5_0002},        // 8  R3
        {1'b1, 8'h1C, 32'h0, 32'h0},                // 9
        {1'b0, 8'h14, 32'h0, 32'hA5A5_0002},        // 10 R3 zero clear no effect
        {1'b0, 8'h3C, 32'h0, 32'h0},                // 11 R6 group 1 untouched
        {1'b1, 8'h40, 32'h0000_8000, 32'h0},        // 12
        {1'b0, 8'h3C, 32'h0, 32'h0000_8000},        // 13 R6
        {1'b0, 8'h14, 32'h0, 32'hA5A5_0002},        // 14 R6 group 0 untouched
        {1'b1, 8'h10, 32'h0000_FFFF, 32'h0},        // 15
        {1'b0, 8'h10, 32'h0, 32'h0000_FFFF},        // 16 R2
        {1'b1, 8'h14, 32'h1234_5678, 32'h0},        // 17
        {1'b0, 8'h14, 32'h0, 32'h1234_5678},        // 18 R4
        {1'b1, 8'h24, 32'h0000_00F0, 32'h0},        // 19
        {1'b1, 8'h28, 32'h0000_0030, 32'h0},        // 20
        {1'b0, 8'h24, 32'h0, 32'h0000_00C0},        // 21 R7
        {1'b0, 8'h28, 32'h0, 32'h0000_00C0},        // 22 R7
        {1'b0, 8'h04, 32'h0, 32'h0},                // 23 R11
        {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},        // 24
        {1'b0, 8'h00, 32'h0, 32'h0},                // 25 R11
        {1'b0, 8'hFC, 32'h0, 32'h0},                // 26 R11
        {1'b0, 8'h12, 32'h0, 32'h0},                // 27 R11 unaligned
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},        // 28
        {1'b0, 8'h08, 32'h0, 32'h0000_03FF},        // 29 R10
        {1'b1, 8'h08, 32'h0, 32'h0},                // 30
        {1'b0, 8'h08, 32'h0, 32'h0},                // 31 R10
        {1'b1, 8'hB8, 32'h0000_0001, 32'h0},        // 32
        {1'b0, 8'hB4, 32'h0, 32'h0000_0001},        // 33 R6 last group
        {1'b0, 8'h10, 32'h0, 32'h0000_FFFF}         // 34 R11 stray write ignored
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        wait_edges(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 ports after reset
        check(pin_oe[31:0], 32'h0, "R1 pin_oe");
        check(32'(bank_irq), 32'h0, "R1 bank_irq");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else            rd(VEC[i][71:64], VEC[i][31:0], $sformatf("table %0d", i));
        end

        // R2 direction and output drive at the pads
        check(pin_oe[31:0], 32'hFFFF_0000, "R2 pin_oe");
        check(pin_out[31:0], 32'h1234_5678, "R2 pin_out");
        check(pin_out[159:128], 32'h0000_0001, "R3 pin_out group 4");

        // R5 synchronizer latency
        @(negedge clk);
        pin_in[31:0] = 32'h0F0F_0000;
        pin_in[33]   = 1'b1;
        @(negedge clk);
        rd(8'h20, 32'h0, "R5 old value after one edge");
        @(negedge clk);
        rd(8'h20, 32'h0F0F_0000, "R5 new value");
        rd(8'h48, 32'h0000_0002, "R5 group 1 input");

        // R8 edge detection and R10 bank lines
        wr(8'h08, 32'h3);
        wr(8'h2C, 32'h0010_0000);
        pin_in[6] = 1'b1; pin_in[5] = 1'b1; pin_in[20] = 1'b1;
        wait_edges(2);
        rd(8'h34, 32'h0, "R8 status not yet set");
        check(32'(bank_irq), 32'h0, "R10 irq idle");
        @(negedge clk);
        rd(8'h34, 32'h0000_0040, "R8 rising edge latched");
        check(32'(bank_irq), 32'h1, "R10 bank 0 line");
        pin_in[20] = 1'b0;
        wait_edges(3);
        rd(8'h34, 32'h0010_0040, "R8 falling edge latched");
        check(32'(bank_irq), 32'h3, "R10 bank 1 line");
        wr(8'h08, 32'h1);
        check(32'(bank_irq), 32'h1, "R10 bank enable gates line");

        // R9 write-one-to-clear
        wr(8'h34, 32'h0);
        rd(8'h34, 32'h0010_0040, "R9 zero write no effect");
        wr(8'h34, 32'h0000_0040);
        rd(8'h34, 32'h0010_0000, "R9 bit cleared");
        check(32'(bank_irq), 32'h0, "R10 line drops after clear");

        // R9 edge and clear on the same clock edge
        pin_in[7] = 1'b1;
        @(negedge clk);
        wr(8'h34, 32'h0010_0080);
        rd(8'h34, 32'h0000_0080, "R9 collision keeps event");

        // R8 both edges on one pin
        wr(8'h24, 32'h0000_0100);
        wr(8'h2C, 32'h0000_0100);
        wr(8'h34, 32'h0000_0080);
        pin_in[8] = 1'b1;
        wait_edges(3);
        rd(8'h34, 32'h0000_0100, "R8 both-edge rise");
        wr(8'h34, 32'h0000_0100);
        pin_in[8] = 1'b0;
        wait_edges(3);
        rd(8'h34, 32'h0000_0100, "R8 both-edge fall");

        // R7 clear words disable detection
        wr(8'h28, 32'h0000_0100);
        wr(8'h30, 32'h0000_0100);
        rd(8'h2C, 32'h0010_0000, "R7 fall enables after clear");
        wr(8'h34, 32'h0000_0100);
        pin_in[8] = 1'b1;
        wait_edges(3);
        rd(8'h34, 32'h0, "R7 disabled edge ignored");

        // R10 upper bank of the last group
        wr(8'h08, 32'h200);
        wr(8'hC4, 32'h0001_0000);
        pin_in[144] = 1'b1;
        wait_edges(3);
        rd(8'hD4, 32'h0001_0000, "R6 group 4 status");
        check(32'(bank_irq), 32'h200, "R10 bank 9 line");

        done = 1'b1;
        summary();
    end
endmodule